// File: doc/BRIEF.md
# Dual-Lane Shared Multiply / Multiply-Accumulate Unit

This block is a small SIMD execute stage built around a four-entry file of 64-bit vector registers. One instruction port supplies an operation select, a destination index and two source indices. In the same cycle the unit reads both sources and runs two 16x16 unsigned multiplier-adders side by side, one per lane. It packs the two 32-bit lane results into a 64-bit word and writes that word to the destination at the next clock edge. Lane 0 takes source bits [15:0]. Lane 1 takes source bits [47:32]. The other source bits are never used.

The two operations use the same physical pair of multiplier-adders. For a multiply-accumulate, each adder is fed the matching 32-bit half of the destination's current value. For a plain multiply, the addend is forced to zero.

A host port writes registers at a clock edge and reads them back combinationally, so it can preload operands and inspect results. A constant count output reports how many multiplier-adder instances were built.

Top module: `dual_mac_unit`

## Requirements
- R1: A synchronous active-low reset clears all four registers to zero.
- R2: When `host_we` is high, `host_wdata` is written to register `host_addr` at the clock edge. `host_rdata` always shows register `host_raddr` combinationally.
- R3: When `ins_valid` is high and `ins_op` is 0 (multiply), the destination receives srcA[15:0]*srcB[15:0] in bits [31:0] and srcA[47:32]*srcB[47:32] in bits [63:32]. Both products are unsigned.
- R4: When `ins_op` is 1 (multiply-accumulate), each 32-bit half of the destination becomes its previous value plus that lane's product, modulo 2^32. No carry passes from bits [31:0] into bits [63:32].
- R5: Source bits [31:16] and [63:48] have no effect on the result.
- R6: The result is visible at the first edge after issue. A back-to-back instruction that names it as a source or destination sees the new value, and the destination may also be one of the sources.
- R7: When neither `ins_valid` nor `host_we` is high, no register changes.
- R8: If the host and an instruction write the same register in the same cycle, the instruction result is stored. If they write different registers, both writes land.
- R9: `mul_count` reports 2, the number of multiplier-adder instances shared by both operations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Instruction issue strobe |
| ins_op | input | 1 | 0 = multiply, 1 = multiply-accumulate |
| ins_dst | input | 2 | Destination register index |
| ins_srca | input | 2 | First source register index |
| ins_srcb | input | 2 | Second source register index |
| host_we | input | 1 | Host write enable |
| host_addr | input | 2 | Host write register index |
| host_wdata | input | 64 | Host write data |
| host_raddr | input | 2 | Host read register index |
| host_rdata | output | 64 | Host read data (combinational) |
| mul_count | output | 2 | Number of multiplier-adder instances |

## Verification
Results from the instruction port and host writes are due one clock edge after the cycle in which they are presented. Host reads and `mul_count` are due in the same cycle as their inputs. The bench drives inputs on the falling edge and lets exactly one rising edge pass. It then sets the read index and samples one nanosecond after the next falling edge, so every expected value is compared in the first cycle it becomes due. The back-to-back and collision tests issue their second operation in the very next cycle, which shows that no extra register stage separates issue from visibility.

// File: rtl/dual_mac_pkg.sv
// Shared sizes and operation codes for the dual-lane multiply unit.
package dual_mac_pkg;
    localparam int REGS      = 4;
    localparam int REG_W     = 64;
    localparam int LANES     = 2;
    localparam int LANE_IN_W = 16;
    localparam int LANE_W    = REG_W / LANES;
    localparam int IDX_W     = $clog2(REGS);
    localparam int CNT_W     = $clog2(LANES + 1);

    typedef enum logic {
        OP_MUL = 1'b0,
        OP_MAC = 1'b1
    } op_e;
endpackage

// File: rtl/vreg_file.sv
// Vector register file with two write ports and a flat view of all entries.
// The instruction write port has priority over the host port on the same index.
// Assumes synchronous active-low reset; reads are done by the parent from the flat bus.
module vreg_file
    import dual_mac_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ex_we,
    input  logic [IDX_W-1:0]       ex_waddr,
    input  logic [REG_W-1:0]       ex_wdata,
    input  logic                   hs_we,
    input  logic [IDX_W-1:0]       hs_waddr,
    input  logic [REG_W-1:0]       hs_wdata,
    output logic [REGS*REG_W-1:0]  regs_flat
);
    logic [REG_W-1:0] store_q [REGS];

    for (genvar g = 0; g < REGS; g++) begin : g_entry
        // Update one entry: reset, then execute write, then host write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                store_q[g] <= '0;
            end else if (ex_we && ex_waddr == IDX_W'(g)) begin
                store_q[g] <= ex_wdata;
            end else if (hs_we && hs_waddr == IDX_W'(g)) begin
                store_q[g] <= hs_wdata;
            end
        end
        assign regs_flat[g*REG_W +: REG_W] = store_q[g];
    end
endmodule

// File: rtl/lane_muladd.sv
// One unsigned 16x16 multiplier with a 32-bit addend; result wraps modulo 2^32.
// Assumes the addend is already forced to zero by the parent for plain multiply.
module lane_muladd
    import dual_mac_pkg::*;
(
    input  logic [LANE_IN_W-1:0] mul_x,
    input  logic [LANE_IN_W-1:0] mul_y,
    input  logic [LANE_W-1:0]    addend,
    output logic [LANE_W-1:0]    result,
    output logic                 present
);
    logic [LANE_W-1:0] product;

    // Form the widened product and add the addend.
    always_comb begin
        product = LANE_W'(mul_x) * LANE_W'(mul_y);
        result  = product + addend;
    end

    assign present = 1'b1;
endmodule

// File: rtl/dual_mac_unit.sv
// Top of the dual-lane multiply / multiply-accumulate unit.
// Reads two sources and the old destination, feeds one shared multiplier-adder
// per lane and writes the packed result at the next edge. Lane i takes source
// bits [i*LANE_W +: LANE_IN_W]. Assumes synchronous active-low reset.
module dual_mac_unit
    import dual_mac_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ins_valid,
    input  logic                 ins_op,
    input  logic [IDX_W-1:0]     ins_dst,
    input  logic [IDX_W-1:0]     ins_srca,
    input  logic [IDX_W-1:0]     ins_srcb,
    input  logic                 host_we,
    input  logic [IDX_W-1:0]     host_addr,
    input  logic [REG_W-1:0]     host_wdata,
    input  logic [IDX_W-1:0]     host_raddr,
    output logic [REG_W-1:0]     host_rdata,
    output logic [CNT_W-1:0]     mul_count
);
    logic [REGS*REG_W-1:0] regs_flat;
    logic [REG_W-1:0]      opnd_a;
    logic [REG_W-1:0]      opnd_b;
    logic [REG_W-1:0]      old_dst;
    logic [REG_W-1:0]      packed_res;
    logic [LANES-1:0]      unit_present;
    op_e                   op_sel;

    assign op_sel = op_e'(ins_op);

    vreg_file u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .ex_we     (ins_valid),
        .ex_waddr  (ins_dst),
        .ex_wdata  (packed_res),
        .hs_we     (host_we),
        .hs_waddr  (host_addr),
        .hs_wdata  (host_wdata),
        .regs_flat (regs_flat)
    );

    // Select the operand, destination and host read words.
    always_comb begin
        opnd_a     = regs_flat[ins_srca   * REG_W +: REG_W];
        opnd_b     = regs_flat[ins_srcb   * REG_W +: REG_W];
        old_dst    = regs_flat[ins_dst    * REG_W +: REG_W];
        host_rdata = regs_flat[host_raddr * REG_W +: REG_W];
    end

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic [LANE_W-1:0] lane_add;
        // Feed the old destination half only for accumulate.
        always_comb begin
            lane_add = (op_sel == OP_MAC) ? old_dst[l*LANE_W +: LANE_W] : '0;
        end
        lane_muladd u_mac (
            .mul_x   (opnd_a[l*LANE_W +: LANE_IN_W]),
            .mul_y   (opnd_b[l*LANE_W +: LANE_IN_W]),
            .addend  (lane_add),
            .result  (packed_res[l*LANE_W +: LANE_W]),
            .present (unit_present[l])
        );
    end

    // Count the multiplier-adder instances that were built.
    always_comb begin
        mul_count = '0;
        for (int i = 0; i < LANES; i++) begin
            mul_count = mul_count + CNT_W'(unit_present[i]);
        end
    end
endmodule

// File: rtl/dual_mac_checker.sv
// Property checker for dual_mac_unit, attached by bind.
// Relates issued instructions and host writes to the register contents one edge later.
module dual_mac_checker
    import dual_mac_pkg::*;
(
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ins_valid,
    input logic                 ins_op,
    input logic [IDX_W-1:0]     ins_dst,
    input logic [IDX_W-1:0]     ins_srca,
    input logic [IDX_W-1:0]     ins_srcb,
    input logic                 host_we,
    input logic [IDX_W-1:0]     host_addr,
    input logic [REG_W-1:0]     host_wdata,
    input logic [CNT_W-1:0]     mul_count,
    input logic [REGS*REG_W-1:0] regs_flat
);
    function automatic logic [REG_W-1:0] pick(input logic [REGS*REG_W-1:0] bus,
                                              input logic [IDX_W-1:0] idx);
        return bus[idx*REG_W +: REG_W];
    endfunction

    function automatic logic [REG_W-1:0] expect_word(input logic acc,
                                                     input logic [REG_W-1:0] a,
                                                     input logic [REG_W-1:0] b,
                                                     input logic [REG_W-1:0] d);
        logic [REG_W-1:0] r;
        for (int l = 0; l < LANES; l++) begin
            r[l*LANE_W +: LANE_W] = LANE_W'(a[l*LANE_W +: LANE_IN_W]) * LANE_W'(b[l*LANE_W +: LANE_IN_W])
                                  + (acc ? d[l*LANE_W +: LANE_W] : '0);
        end
        return r;
    endfunction

    // R1: reset leaves every register at zero one edge later
    p_reset_clear_r1: assert property (@(posedge clk) !rst_n |=> regs_flat == '0);

    // R2: uncontested host write lands
    p_host_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_we && !(ins_valid && ins_dst == host_addr))
        |=> pick(regs_flat, $past(host_addr)) == $past(host_wdata));

    // R3, R4, R5: instruction result per lane, from the operands one edge earlier
    p_exec_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> pick(regs_flat, $past(ins_dst)) ==
            expect_word($past(ins_op),
                        pick($past(regs_flat), $past(ins_srca)),
                        pick($past(regs_flat), $past(ins_srcb)),
                        pick($past(regs_flat), $past(ins_dst))));

    // R7: idle cycles leave the file unchanged
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!ins_valid && !host_we) |=> $stable(regs_flat));

    // R9: two multiplier-adders present
    p_two_units_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mul_count == CNT_W'(2));
endmodule

bind dual_mac_unit dual_mac_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_valid  (ins_valid),
    .ins_op     (ins_op),
    .ins_dst    (ins_dst),
    .ins_srca   (ins_srca),
    .ins_srcb   (ins_srcb),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .mul_count  (mul_count),
    .regs_flat  (regs_flat)
);

// File: tb/tb_dual_mac_unit.sv
module tb_dual_mac_unit;
    import dual_mac_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              ins_valid = 1'b0;
    logic              ins_op = 1'b0;
    logic [1:0]        ins_dst = '0, ins_srca = '0, ins_srcb = '0;
    logic              host_we = 1'b0;
    logic [1:0]        host_addr = '0, host_raddr = '0;
    logic [63:0]       host_wdata = '0;
    logic [63:0]       host_rdata;
    logic [1:0]        mul_count;

    int checks = 0;
    int failures = 0;
    logic [63:0] model [4];

    always #2 clk = ~clk;

    dual_mac_unit dut (
        .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_op(ins_op),
        .ins_dst(ins_dst), .ins_srca(ins_srca), .ins_srcb(ins_srcb),
        .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata), .mul_count(mul_count)
    );

    localparam int NV = 8;
    localparam logic        VOP [NV] = '{1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1};
    localparam logic [63:0] VA  [NV] = '{
        64'h0000_0000_0000_0003, 64'h0000_FFFF_0000_FFFF, 64'h1234_0010_ABCD_0100,
        64'h0000_0002_0000_0005, 64'h0000_FFFF_0000_FFFF, 64'h0000_0001_0000_0001,
        64'hFFFF_8000_FFFF_8000, 64'h0000_1000_0000_0000};
    localparam logic [63:0] VB  [NV] = '{
        64'h0000_0000_0000_0007, 64'h0000_FFFF_0000_FFFF, 64'h5678_0020_EF01_0200,
        64'h0000_0003_0000_0004, 64'h0000_FFFF_0000_0001, 64'h0000_0001_0000_0001,
        64'hFFFF_0002_FFFF_0002, 64'h0000_1000_0000_FFFF};
    localparam logic [63:0] VD  [NV] = '{
        64'hDEAD_BEEF_DEAD_BEEF, 64'h0, 64'h1111_1111_2222_2222,
        64'h0000_0010_0000_0020, 64'h0000_0001_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h5555_5555_5555_5555, 64'hFF00_0000_0000_0001};

    function automatic logic [63:0] ref_calc(input logic acc, input logic [63:0] a,
                                             input logic [63:0] b, input logic [63:0] d);
        logic [63:0] r;
        logic [31:0] p0, p1;
        p0 = {16'h0, a[15:0]}  * {16'h0, b[15:0]};
        p1 = {16'h0, a[47:32]} * {16'h0, b[47:32]};
        r[31:0]  = p0 + (acc ? d[31:0]  : 32'h0);
        r[63:32] = p1 + (acc ? d[63:32] : 32'h0);
        return r;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_write(input logic [1:0] a, input logic [63:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
        model[a] = d;
    endtask

    task automatic issue(input logic op, input logic [1:0] d, input logic [1:0] a, input logic [1:0] b);
        @(negedge clk);
        ins_valid = 1'b1; ins_op = op; ins_dst = d; ins_srca = a; ins_srcb = b;
        @(negedge clk);
        ins_valid = 1'b0;
        model[d] = ref_calc(op, model[a], model[b], model[d]);
    endtask

    task automatic read_check(input string tag, input logic [1:0] a, input logic [63:0] exp);
        host_raddr = a;
        #1;
        check(tag, host_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) model[i] = '0;
    endtask

    initial begin
        #700000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        logic [63:0] r_clean;
        do_reset();
        // R1: all registers zero after reset
        for (int i = 0; i < 4; i++) read_check("R1 reset", 2'(i), 64'h0);
        // R9: two multiplier-adder instances
        checks++;
        if (mul_count !== 2'd2) begin
            failures++;
            $display("FAIL R9 mul_count actual=%0d expected=2", mul_count);
        end
        // R2: host write then read
        host_write(2'd3, 64'hCAFE_F00D_0123_4567);
        read_check("R2 host write", 2'd3, 64'hCAFE_F00D_0123_4567);

        // Vector table: R3 multiply / R4 accumulate
        for (int v = 0; v < NV; v++) begin
            host_write(2'd0, VA[v]);
            host_write(2'd1, VB[v]);
            host_write(2'd2, VD[v]);
            issue(VOP[v], 2'd2, 2'd0, 2'd1);
            read_check(VOP[v] ? "R4 table mac" : "R3 table mul", 2'd2,
                       ref_calc(VOP[v], VA[v], VB[v], VD[v]));
        end

        // R5: ignored source bits
        host_write(2'd0, 64'h0000_0123_0000_0456);
        host_write(2'd1, 64'h0000_0789_0000_0ABC);
        issue(1'b0, 2'd2, 2'd0, 2'd1);
        host_raddr = 2'd2; #1; r_clean = host_rdata;
        host_write(2'd0, 64'hFFFF_0123_FFFF_0456);
        host_write(2'd1, 64'hA5A5_0789_5A5A_0ABC);
        issue(1'b0, 2'd3, 2'd0, 2'd1);
        read_check("R5 ignored bits", 2'd3, r_clean);

        // R4: no carry between halves
        host_write(2'd0, 64'h0000_0000_0000_0001);
        host_write(2'd1, 64'h0000_0000_0000_0001);
        host_write(2'd2, 64'h0000_0000_FFFF_FFFF);
        issue(1'b1, 2'd2, 2'd0, 2'd1);
        read_check("R4 no carry", 2'd2, 64'h0);

        // R6: back-to-back, second uses first result, dst equal to source
        host_write(2'd0, 64'h0000_0003_0000_0002);
        host_write(2'd1, 64'h0000_0005_0000_0007);
        @(negedge clk);
        ins_valid = 1'b1; ins_op = 1'b0; ins_dst = 2'd2; ins_srca = 2'd0; ins_srcb = 2'd1;
        model[2] = ref_calc(1'b0, model[0], model[1], model[2]);
        @(negedge clk);
        ins_op = 1'b1; ins_dst = 2'd2; ins_srca = 2'd2; ins_srcb = 2'd2;
        model[2] = ref_calc(1'b1, model[2], model[2], model[2]);
        @(negedge clk);
        ins_valid = 1'b0;
        read_check("R6 back to back", 2'd2, model[2]);

        // R7: idle cycles with changing selects change nothing
        @(negedge clk);
        ins_dst = 2'd0; ins_op = 1'b1; host_addr = 2'd1; host_wdata = '1;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 4; i++) read_check("R7 idle hold", 2'(i), model[i]);

        // R8: collision on the same register, instruction wins
        @(negedge clk);
        host_we = 1'b1; host_addr = 2'd3; host_wdata = 64'h1111_2222_3333_4444;
        ins_valid = 1'b1; ins_op = 1'b0; ins_dst = 2'd3; ins_srca = 2'd0; ins_srcb = 2'd1;
        model[3] = ref_calc(1'b0, model[0], model[1], model[3]);
        @(negedge clk);
        host_we = 1'b0; ins_valid = 1'b0;
        read_check("R8 same target", 2'd3, model[3]);
        // R8: different targets, both land
        @(negedge clk);
        host_we = 1'b1; host_addr = 2'd1; host_wdata = 64'h0BAD_0BAD_0BAD_0BAD;
        ins_valid = 1'b1; ins_op = 1'b1; ins_dst = 2'd2; ins_srca = 2'd0; ins_srcb = 2'd1;
        model[2] = ref_calc(1'b1, model[0], model[1], model[2]);
        model[1] = 64'h0BAD_0BAD_0BAD_0BAD;
        @(negedge clk);
        host_we = 1'b0; ins_valid = 1'b0;
        read_check("R8 split host", 2'd1, model[1]);
        read_check("R8 split ins", 2'd2, model[2]);

        // R3 R4 random sequences against the model
        for (int i = 0; i < 4; i++) host_write(2'(i), {$urandom, $urandom});
        for (int n = 0; n < 300; n++) begin
            logic [1:0] d, a, b;
            logic op;
            d = 2'($urandom); a = 2'($urandom); b = 2'($urandom); op = 1'($urandom);
            if (($urandom % 8) == 0) host_write(2'($urandom), {$urandom, $urandom});
            issue(op, d, a, b);
            read_check(op ? "R4 random mac" : "R3 random mul", d, model[d]);
        end

        // R1: reset mid-run clears everything
        do_reset();
        for (int i = 0; i < 4; i++) read_check("R1 reset again", 2'(i), 64'h0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule